// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is a bank of identical output cells for a sum-of-products logic array. Each cell takes the OR-sum of its product terms and produces three things: a pin drive value, a pin output enable, and a feedback bit that returns to the array. Two configuration bits per cell pick the cell's mode. One bit selects a registered path through a rising-edge D flip-flop or a combinational path that bypasses it. The other bit selects active-high or active-low pin polarity.

All cells share two control terms and a test mode. The clear term forces every cell flip-flop LOW at once, without waiting for a clock. The set term loads HIGH into every flip-flop on the next rising edge. The preload mode turns all pin drivers off, and on a rising edge it copies the value seen on each pin into that cell's flip-flop. This lets a test reach any register state directly.

When a cell's enable term is held false, the cell never drives its pin. In combinational mode the cell then serves as a plain input, because the feedback follows the pin. The system reset is active-low. It is asserted asynchronously and released synchronously, and it leaves every flip-flop LOW.

Top module: `omc_bank`

## Requirements
- R1: With mode bit 1 (S1) at 0, the cell is registered. Its pin value is the flip-flop state when mode bit 0 (S0) is 1, and the inverse of that state when S0 is 0.
- R2: With S1 at 1, the cell is combinational. Its pin value is the sum input in the same cycle when S0 is 1, and the inverted sum input when S0 is 0.
- R3: When none of clear, set or preload is active, the flip-flop takes the sum input on each rising clock edge.
- R4: While the clear term is high, the flip-flop is LOW at once, without a clock edge. Clear also overrides both set and preload.
- R5: When the set term is high and preload is off, the flip-flop loads HIGH on the next rising edge, whatever the sum input is.
- R6: Clear and set act on the flip-flop state. The pin level that results depends on S0, so a registered active-low cell shows 1 on its pin after a clear.
- R7: The feedback is the flip-flop state in registered mode and the pin input in combinational mode.
- R8: When the enable term is 0, the pin is not driven. A combinational cell then passes its pin input to the feedback, acting as a dedicated input.
- R9: The pin output enable follows the cell's enable term whenever preload is off.
- R10: Preload forces every pin output enable to 0. On a rising edge it loads each flip-flop from its pin input, and it takes precedence over set.
- R11: While the system reset is low, every flip-flop is LOW. The reset is released on the second rising edge after the reset input goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flip-flops load on its rising edge |
| rst_n | input | 1 | System reset, active low, asserted asynchronously and released synchronously |
| cfg_mode | input | 2*CELLS | Per-cell mode; bits [2i+1:2i] of cell i are {S1,S0} (00 registered active-low, 01 registered active-high, 10 combinational active-low, 11 combinational active-high) |
| sum_in | input | CELLS | Per-cell OR-sum from the array |
| oe_term | input | CELLS | Per-cell output-enable product term |
| clear_term | input | 1 | Shared asynchronous clear of all flip-flops, active high |
| set_term | input | 1 | Shared synchronous set of all flip-flops, active high |
| preload_en | input | 1 | Test preload mode: pins undriven, flip-flops load from the pins |
| pin_in | input | CELLS | Value currently present on each pin |
| pin_out | output | CELLS | Value each cell drives onto its pin |
| pin_oe | output | CELLS | Drive enable for each pin |
| fb_out | output | CELLS | Feedback bit from each cell to the array |

## Verification
The assertions check on every cycle the state rules, which hold no matter which mode the cells are in. Under clear, the state is LOW. After a normal edge the state equals the sum input from the previous cycle. After a set edge it is HIGH, and after a preload edge it equals the pin input from the previous cycle. Preload never leaves a driver on, and a registered cell shows the level S0 calls for after a clear. The bench covers what depends on the mode decode. It sweeps every mode against all combinations of the sum, pin, enable, set and preload inputs, and compares the pin value and feedback with a model. It also runs directed scenarios. One shows that clear acts between clock edges and overrides set and preload together. Another shows that the flip-flops hold LOW through the reset release.

// File: rtl/omc_pkg.sv
package omc_pkg;

  // Cell mode: bit 1 selects the flip-flop bypass, bit 0 the pin polarity.
  typedef enum logic [1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } omc_mode_e;

  function automatic logic mode_is_registered(omc_mode_e m);
    return ~m[1];
  endfunction

  function automatic logic mode_is_active_high(omc_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/omc_rst_sync.sv
module omc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/omc_state_reg.sv
module omc_state_reg (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic clear_term,
  input  logic set_term,
  input  logic preload_en,
  input  logic sum_in,
  input  logic pin_in,
  output logic state_q
);

  logic state_d;
  logic clr_n;

  // Async clear path: system reset or the clear product term.
  assign clr_n = rst_sync_n & ~clear_term;

  // Preload over set over normal load.
  always_comb begin
    if (preload_en) begin
      state_d = pin_in;
    end else if (set_term) begin
      state_d = 1'b1;
    end else begin
      state_d = sum_in;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      state_q <= 1'b0;
    end else begin
      state_q <= state_d;
    end
  end

  // R4
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clear_term |-> !state_q);

  // R3
  normal_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clear_term && !set_term && !preload_en) |=> (clear_term || state_q == $past(sum_in)));

  // R5
  set_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clear_term && set_term && !preload_en) |=> (clear_term || state_q));

  // R10
  preload_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clear_term && preload_en) |=> (clear_term || state_q == $past(pin_in)));

endmodule

// File: rtl/omc_out_path.sv
module omc_out_path
  import omc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sync_n,
  input  omc_mode_e mode,
  input  logic      state_q,
  input  logic      sum_in,
  input  logic      oe_term,
  input  logic      preload_en,
  input  logic      pin_in,
  output logic      pin_out,
  output logic      pin_oe,
  output logic      fb_out
);

  logic selected;

  always_comb begin
    selected = mode_is_registered(mode) ? state_q : sum_in;
    pin_out  = mode_is_active_high(mode) ? selected : ~selected;
    pin_oe   = oe_term & ~preload_en;
    fb_out   = mode_is_registered(mode) ? state_q : pin_in;
  end

  // R10
  preload_hiz_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    preload_en |-> !pin_oe);

endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  logic [1:0] mode_bits,
  input  logic       sum_in,
  input  logic       oe_term,
  input  logic       clear_term,
  input  logic       set_term,
  input  logic       preload_en,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out
);

  omc_mode_e mode;
  logic      state_q;

  assign mode = omc_mode_e'(mode_bits);

  omc_state_reg i_state (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .clear_term (clear_term),
    .set_term   (set_term),
    .preload_en (preload_en),
    .sum_in     (sum_in),
    .pin_in     (pin_in),
    .state_q    (state_q)
  );

  omc_out_path i_path (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .mode       (mode),
    .state_q    (state_q),
    .sum_in     (sum_in),
    .oe_term    (oe_term),
    .preload_en (preload_en),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .fb_out     (fb_out)
  );

  // R6
  clear_pin_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clear_term && !mode_bits[1]) |-> (pin_out == ~mode_bits[0]));

endmodule

// File: rtl/omc_bank.sv
module omc_bank #(
  parameter int CELLS      = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*CELLS-1:0] cfg_mode,
  input  logic [CELLS-1:0]   sum_in,
  input  logic [CELLS-1:0]   oe_term,
  input  logic               clear_term,
  input  logic               set_term,
  input  logic               preload_en,
  input  logic [CELLS-1:0]   pin_in,
  output logic [CELLS-1:0]   pin_out,
  output logic [CELLS-1:0]   pin_oe,
  output logic [CELLS-1:0]   fb_out
);

  localparam int MODE_W = 2;

  logic rst_sync_n;

  omc_rst_sync #(.STAGES(SYNC_DEPTH)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    omc_cell i_cell (
      .clk        (clk),
      .rst_sync_n (rst_sync_n),
      .mode_bits  (cfg_mode[MODE_W*c +: MODE_W]),
      .sum_in     (sum_in[c]),
      .oe_term    (oe_term[c]),
      .clear_term (clear_term),
      .set_term   (set_term),
      .preload_en (preload_en),
      .pin_in     (pin_in[c]),
      .pin_out    (pin_out[c]),
      .pin_oe     (pin_oe[c]),
      .fb_out     (fb_out[c])
    );
  end

endmodule

// File: tb/test_omc_bank.sv
module test_omc_bank;

  localparam int  CELLS      = 4;
  localparam time CLK_PERIOD = 10;
  localparam int  MAX_CYCLES = 200000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [2*CELLS-1:0] cfg_mode;
  logic [CELLS-1:0]   sum_in, oe_term, pin_in;
  logic               clear_term, set_term, preload_en;
  logic [CELLS-1:0]   pin_out, pin_oe, fb_out;

  omc_bank #(.CELLS(CELLS)) i_omc_bank (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .sum_in(sum_in),
    .oe_term(oe_term), .clear_term(clear_term), .set_term(set_term),
    .preload_en(preload_en), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb_out(fb_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 1'b0;
  logic  q_exp [CELLS];
  string why   [CELLS];

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  task automatic set_modes(input int rot);
    for (int i = 0; i < CELLS; i++) cfg_mode[2*i +: 2] = 2'((i + rot) % 4);
  endtask

  // Compare every cell against the model built from the requirements.
  task automatic check_cells();
    for (int i = 0; i < CELLS; i++) begin
      logic [1:0] m;
      logic reg_mode, src, e_pin;
      m        = cfg_mode[2*i +: 2];
      reg_mode = ~m[1];
      src      = reg_mode ? q_exp[i] : sum_in[i];
      e_pin    = m[0] ? src : ~src;
      chk(pin_out[i], e_pin, reg_mode ? {"R1/", why[i]} : "R2", $sformatf("pin_out[%0d]", i));
      chk(pin_oe[i], oe_term[i] & ~preload_en, preload_en ? "R10" : (oe_term[i] ? "R9" : "R8"),
          $sformatf("pin_oe[%0d]", i));
      chk(fb_out[i], reg_mode ? q_exp[i] : pin_in[i], (!reg_mode && !oe_term[i]) ? "R7/R8" : "R7",
          $sformatf("fb_out[%0d]", i));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clear_term = 1'b0; set_term = 1'b0; preload_en = 1'b0;
    sum_in = '0; oe_term = '0; pin_in = '0;
    set_modes(0);
    for (int i = 0; i < CELLS; i++) begin q_exp[i] = 1'b0; why[i] = "R11"; end

    // R11: state LOW during reset, even with set asserted.
    repeat (3) @(posedge clk);
    @(negedge clk); set_term = 1'b1; sum_in = '1;
    @(posedge clk); @(negedge clk); #1;
    sum_in = '0; #1;
    check_cells();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    // R11: one edge after release the flip-flops are still held LOW.
    check_cells();
    @(negedge clk); set_term = 1'b0;
    repeat (2) @(posedge clk);

    // Near-exhaustive sweep: every mode on every cell, all input combinations.
    for (int rot = 0; rot < 4; rot++) begin
      set_modes(rot);
      for (int v = 0; v < 16384; v++) begin
        logic [13:0] vb;
        logic nxt [CELLS];
        string nwhy;
        vb = 14'(v);
        @(negedge clk);
        sum_in = vb[3:0]; pin_in = vb[7:4]; oe_term = vb[11:8];
        set_term = vb[12]; preload_en = vb[13];
        #1;
        check_cells();
        nwhy = preload_en ? "R10" : (set_term ? "R5" : "R3");
        for (int i = 0; i < CELLS; i++)
          nxt[i] = preload_en ? pin_in[i] : (set_term ? 1'b1 : sum_in[i]);
        @(posedge clk);
        for (int i = 0; i < CELLS; i++) begin q_exp[i] = nxt[i]; why[i] = nwhy; end
      end
    end

    // R4, R6: clear acts between edges and beats set and preload.
    @(negedge clk); set_term = 1'b1; preload_en = 1'b0; sum_in = '0; pin_in = '1; oe_term = '1;
    @(posedge clk);
    for (int i = 0; i < CELLS; i++) begin q_exp[i] = 1'b1; why[i] = "R5"; end
    @(negedge clk); #1;
    check_cells();
    #1 clear_term = 1'b1; preload_en = 1'b1;
    #1;
    for (int i = 0; i < CELLS; i++) begin q_exp[i] = 1'b0; why[i] = "R4/R6"; end
    check_cells();
    @(posedge clk); @(negedge clk); #1;
    check_cells();
    clear_term = 1'b0; set_term = 1'b0; preload_en = 1'b0;
    #1;
    check_cells();

    finish_run();
  end

endmodule